// File: doc/BRIEF.md
# Host Register Bridge for a Network Controller

This block lets a host reach the 16-bit internal registers of a network controller through a small byte-wide memory window. The host first writes a control byte, which picks the register-address port or the data port of the controller and sets the transfer direction. For a write, it then loads the outgoing word a byte at a time. A write of any value to the command byte starts one 16-bit transfer on the controller side. The host polls a busy flag in the status byte until the transfer is done. After a read transfer, it fetches the returned word from the same byte addresses it used for the outgoing word.

The outgoing and returned words are held in separate registers that share one address, so reading the data window never shows what was last written. The control byte is write-only and the status byte is read-only, and both sit at one offset. The control byte also drives an active-low reset line to the controller. The status byte carries an inverted interrupt flag from the controller.

Window offsets: lane bytes at offsets 0 to LANES-1 (offset 0 is bits 7:0 of the word), control/status at offset LANES, command at offset LANES+1. With the defaults these are 0, 1, 2 and 3.

Top module: `ctl_reg_bridge`

## Requirements
- R1: After reset, busy is 0, `ctlReq` is 0, `ctlResetN` is 0, and both returned-data bytes read as 0.
- R2: Host writes to lane offsets load the outgoing word, which appears on `ctlWrData` during the next transfer. Host reads of lane offsets return the returned-data register, never the outgoing bytes.
- R3: Control bit 0 sets the transfer target: 1 drives `ctlAddrSel` high (address port) and 0 drives it low (data port).
- R4: Control bit 1 sets the direction: 1 drives `ctlRead` high (read from the controller) and 0 drives it low (write to it).
- R5: Control bit 3 drives `ctlResetN` from the cycle after the control write. A value of 0 holds the controller in reset.
- R6: A host write to the command offset while idle starts one transfer whatever the data value. `ctlReq` is high from the next cycle.
- R7: Status bit 5 reads 1 from the command write until the clock edge at which `ctlReady` is seen with `ctlReq` high, and then reads 0.
- R8: Status bit 4 is the inverse of `ctlIrq`: it reads 0 while the controller requests an interrupt. All other status bits read 0.
- R9: A read transfer loads `ctlRdData` into the returned-data register on its completing edge. A write transfer leaves that register unchanged.
- R10: A command write that arrives while busy is ignored. The transfer in flight goes on and completes only once.
- R11: Target, direction and outgoing word are captured when a transfer starts. Control or lane writes made while busy do not alter `ctlAddrSel`, `ctlRead` or `ctlWrData` until the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | ADDR_W | Window offset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | BYTE_W | Host write byte |
| hostRdEn | input | 1 | Host read strobe |
| hostRdData | output | BYTE_W | Read byte, valid the cycle after `hostRdEn` |
| ctlReq | output | 1 | Transfer request, high while busy |
| ctlAddrSel | output | 1 | 1 = address port, 0 = data port |
| ctlRead | output | 1 | 1 = read from controller, 0 = write |
| ctlWrData | output | DATA_W | Word sent to the controller |
| ctlRdData | input | DATA_W | Word returned by the controller |
| ctlReady | input | 1 | Completion handshake |
| ctlIrq | input | 1 | Controller interrupt request, active high |
| ctlResetN | output | 1 | Controller reset, active low |

## Verification
A host write is captured at the next rising edge, so `ctlReq`, `ctlResetN` and the captured transfer fields are sampled one falling edge after the write strobe is dropped. Host reads are registered, so the bench raises `hostRdEn` at a falling edge and samples `hostRdData` at the following falling edge. The bench replies on `ctlReady` after a programmable number of request cycles. It polls the busy bit until it clears and only then reads the returned word, so it never depends on the exact completion cycle. For the in-flight checks, the responder withholds ready and the bench samples the controller-side outputs while the transfer is stalled.

// File: rtl/ctl_reg_bridge_pkg.sv
package ctl_reg_bridge_pkg;

  // Control byte bit positions
  localparam int CTRL_SEL_BIT = 0;
  localparam int CTRL_DIR_BIT = 1;
  localparam int CTRL_RST_BIT = 3;

  // Status byte bit positions
  localparam int STAT_IRQN_BIT = 4;
  localparam int STAT_BUSY_BIT = 5;

  typedef enum logic {
    XFER_IDLE = 1'b0,
    XFER_BUSY = 1'b1
  } xferState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic dataWr;   // host write to a lane offset
    logic ctrlWr;   // host write to control offset
    logic start;    // transfer begins, capture fields
    logic capture;  // transfer completes this edge
    logic busy;     // transfer in progress
  } bridgeStrb_t;

endpackage

// File: rtl/ctl_reg_bridge_ctrl.sv
module ctl_reg_bridge_ctrl
  import ctl_reg_bridge_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              ctlReady,
  output bridgeStrb_t       strb
);

  localparam int OFF_CTRL = LANES;
  localparam int OFF_CMD  = LANES + 1;

  xferState_e stateQ, stateD;
  logic cmdHit;
  logic laneHit;

  always_comb begin
    laneHit = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (hostAddr == ADDR_W'(i)) laneHit = 1'b1;
    end
  end

  assign cmdHit = hostWrEn && (hostAddr == ADDR_W'(OFF_CMD));

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      XFER_IDLE: if (cmdHit) stateD = XFER_BUSY;
      XFER_BUSY: if (ctlReady) stateD = XFER_IDLE;
      default:   stateD = XFER_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= XFER_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.dataWr  = hostWrEn && laneHit;
    strb.ctrlWr  = hostWrEn && (hostAddr == ADDR_W'(OFF_CTRL));
    strb.start   = cmdHit && (stateQ == XFER_IDLE);
    strb.capture = (stateQ == XFER_BUSY) && ctlReady;
    strb.busy    = (stateQ == XFER_BUSY);
  end

  // R6: an idle command write of any value makes the bridge busy
  assert_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && !strb.busy) |=> strb.busy);

  // R7: the ready handshake ends the transfer
  assert_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && ctlReady) |=> !strb.busy);

  // R10: without ready, a busy bridge stays busy even under a new command
  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !ctlReady) |=> strb.busy);

endmodule

// File: rtl/ctl_reg_bridge_dp.sv
module ctl_reg_bridge_dp
  import ctl_reg_bridge_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  parameter int ADDR_W = 2,
  parameter int DATA_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStrb_t       strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic [DATA_W-1:0] ctlRdData,
  input  logic              ctlIrq,
  output logic              ctlAddrSel,
  output logic              ctlRead,
  output logic [DATA_W-1:0] ctlWrData,
  output logic              ctlResetN
);

  localparam int OFF_CTRL = LANES;

  logic [LANES-1:0][BYTE_W-1:0] wrByte;
  logic [LANES-1:0][BYTE_W-1:0] rdByte;
  logic              selQ, dirQ, rstQ;
  logic              xferSel, xferDir;
  logic [DATA_W-1:0] xferWord;
  logic [BYTE_W-1:0] statusByte;
  logic [BYTE_W-1:0] rdMux;

  // Per-lane outgoing and returned bytes
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN)
        wrByte[g] <= '0;
      else if (strb.dataWr && hostAddr == ADDR_W'(g))
        wrByte[g] <= hostWrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        rdByte[g] <= '0;
      else if (strb.capture && xferDir)
        rdByte[g] <= ctlRdData[g*BYTE_W +: BYTE_W];
    end
  end

  // Control byte: only the meaningful bits are kept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= 1'b0;
      dirQ <= 1'b0;
      rstQ <= 1'b0;
    end else if (strb.ctrlWr) begin
      selQ <= hostWrData[CTRL_SEL_BIT];
      dirQ <= hostWrData[CTRL_DIR_BIT];
      rstQ <= hostWrData[CTRL_RST_BIT];
    end
  end

  // Transfer fields captured at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferSel  <= 1'b0;
      xferDir  <= 1'b0;
      xferWord <= '0;
    end else if (strb.start) begin
      xferSel  <= selQ;
      xferDir  <= dirQ;
      xferWord <= wrByte;
    end
  end

  always_comb begin
    statusByte                = '0;
    statusByte[STAT_BUSY_BIT] = strb.busy;
    statusByte[STAT_IRQN_BIT] = ~ctlIrq;
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < LANES; i++) begin
      if (hostAddr == ADDR_W'(i)) rdMux = rdByte[i];
    end
    if (hostAddr == ADDR_W'(OFF_CTRL)) rdMux = statusByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         hostRdData <= '0;
    else if (hostRdEn) hostRdData <= rdMux;
  end

  assign ctlAddrSel = xferSel;
  assign ctlRead    = xferDir;
  assign ctlWrData  = xferWord;
  assign ctlResetN  = rstQ;

  // R11: captured fields hold for the whole transfer
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.capture) |=> ($stable(ctlWrData) && $stable(ctlAddrSel) && $stable(ctlRead)));

  // R9: returned data changes only on a completing edge
  assert_rdhold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rdByte));

  // R5: the reset line moves only after a control write
  assert_rst_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlWr |=> $stable(ctlResetN));

endmodule

// File: rtl/ctl_reg_bridge.sv
module ctl_reg_bridge
  import ctl_reg_bridge_pkg::*;
#(
  parameter  int BYTE_W = 8,
  parameter  int LANES  = 2,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int ADDR_W = $clog2(LANES + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic              hostRdEn,
  output logic [BYTE_W-1:0] hostRdData,
  output logic              ctlReq,
  output logic              ctlAddrSel,
  output logic              ctlRead,
  output logic [DATA_W-1:0] ctlWrData,
  input  logic [DATA_W-1:0] ctlRdData,
  input  logic              ctlReady,
  input  logic              ctlIrq,
  output logic              ctlResetN
);

  bridgeStrb_t strb;

  ctl_reg_bridge_ctrl #(
    .LANES (LANES),
    .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .hostAddr(hostAddr),
    .hostWrEn(hostWrEn),
    .ctlReady(ctlReady),
    .strb    (strb)
  );

  ctl_reg_bridge_dp #(
    .BYTE_W(BYTE_W),
    .LANES (LANES),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostRdEn  (hostRdEn),
    .hostRdData(hostRdData),
    .ctlRdData (ctlRdData),
    .ctlIrq    (ctlIrq),
    .ctlAddrSel(ctlAddrSel),
    .ctlRead   (ctlRead),
    .ctlWrData (ctlWrData),
    .ctlResetN (ctlResetN)
  );

  assign ctlReq = strb.busy;

endmodule

// File: tb/ctl_reg_bridge_tb_top.sv
module ctl_reg_bridge_tb_top;

  localparam logic [1:0] A_LO   = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_CMD  = 2'd3;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  hostAddr;
  logic        hostWrEn;
  logic [7:0]  hostWrData;
  logic        hostRdEn;
  logic [7:0]  hostRdData;
  logic        ctlReq, ctlAddrSel, ctlRead, ctlResetN;
  logic [15:0] ctlWrData;
  logic [15:0] ctlRdData;
  logic        ctlReady;
  logic        ctlIrq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // Responder state
  int          respLat  = 0;
  bit          respHold = 0;
  int          waitCnt  = 0;
  int          xferCnt  = 0;
  logic [1:0]  rspRap   = '0;
  logic [15:0] rspRegs [4];

  // Bench shadow of the controller
  logic [1:0]  shRap = '0;
  logic [15:0] shRegs [4];
  logic [15:0] shRd  = '0;

  always #10 clk = ~clk;

  ctl_reg_bridge dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .ctlReq(ctlReq), .ctlAddrSel(ctlAddrSel), .ctlRead(ctlRead),
    .ctlWrData(ctlWrData), .ctlRdData(ctlRdData), .ctlReady(ctlReady),
    .ctlIrq(ctlIrq), .ctlResetN(ctlResetN)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Simple register-file responder on the controller side
  initial begin
    ctlReady  = 1'b0;
    ctlRdData = '0;
    for (int i = 0; i < 4; i++) rspRegs[i] = '0;
    forever begin
      @(negedge clk);
      if (ctlReady) begin
        ctlReady = 1'b0;
        waitCnt  = 0;
      end else if (ctlReq === 1'b1 && rstN && !respHold) begin
        if (waitCnt >= respLat) begin
          if (ctlRead)        ctlRdData = ctlAddrSel ? {14'd0, rspRap} : rspRegs[rspRap];
          else if (ctlAddrSel) rspRap = ctlWrData[1:0];
          else                 rspRegs[rspRap] = ctlWrData;
          xferCnt++;
          ctlReady = 1'b1;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic hostWrite(input logic [1:0] a, input logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [7:0] d);
    hostAddr = a; hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  function automatic logic [7:0] expStatus(input bit busy, input bit irq);
    return {2'b00, busy, ~irq, 4'b0000};
  endfunction

  task automatic waitIdle(input string tag);
    logic [7:0] s;
    int n = 0;
    do begin
      hostRead(A_CTRL, s);
      n++;
    end while (s[5] && n < 60);
    check(!s[5], tag, {24'd0, s}, {24'd0, expStatus(0, ctlIrq)});
  endtask

  // One full transfer; updates the shadow model
  task automatic doXfer(input bit sel, input bit dir, input logic [15:0] w,
                        input int lat, input logic [7:0] cmdVal, input string tag);
    hostWrite(A_CTRL, {4'b0000, 1'b1, 1'b0, dir, sel});
    hostWrite(A_LO, w[7:0]);
    hostWrite(A_HI, w[15:8]);
    respLat = lat;
    hostWrite(A_CMD, cmdVal);
    waitIdle(tag);
    if (dir) shRd = sel ? {14'd0, shRap} : shRegs[shRap];
    else if (sel) shRap = w[1:0];
    else shRegs[shRap] = w;
  endtask

  task automatic readWord(output logic [15:0] w);
    logic [7:0] lo, hi;
    hostRead(A_LO, lo);
    hostRead(A_HI, hi);
    w = {hi, lo};
  endtask

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int          c0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) shRegs[i] = '0;
    rstN = 1'b0; hostAddr = '0; hostWrEn = 0; hostWrData = '0; hostRdEn = 0; ctlIrq = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(ctlReq == 0, "R1 ctlReq", ctlReq, 0);
    check(ctlResetN == 0, "R1 ctlResetN", ctlResetN, 0);
    hostRead(A_CTRL, b);
    check(b == expStatus(0, 0), "R1 status", b, expStatus(0, 0));
    readWord(w);
    check(w == 16'h0000, "R1 read word", w, 0);

    // R5 reset line
    hostWrite(A_CTRL, 8'h08);
    check(ctlResetN == 1, "R5 release", ctlResetN, 1);
    hostWrite(A_CTRL, 8'hF7);
    check(ctlResetN == 0, "R5 assert", ctlResetN, 0);
    hostWrite(A_CTRL, 8'h08);
    check(ctlResetN == 1, "R5 release again", ctlResetN, 1);

    // R8 interrupt flag
    ctlIrq = 1;
    hostRead(A_CTRL, b);
    check(b == expStatus(0, 1), "R8 irq set", b, expStatus(0, 1));
    ctlIrq = 0;
    hostRead(A_CTRL, b);
    check(b == expStatus(0, 0), "R8 irq clear", b, expStatus(0, 0));

    // R3 R4 R9 directed: address port, data write, read back
    doXfer(1, 0, 16'h0002, 0, 8'h00, "R3 addr write idle");
    doXfer(0, 0, 16'hBEEF, 2, 8'hFF, "R4 data write idle");
    readWord(w);
    check(w == 16'h0000, "R9 write leaves read reg", w, 0);
    doXfer(0, 1, 16'h1234, 1, 8'h5A, "R4 data read idle");
    readWord(w);
    check(w == shRd, "R9 read data", w, shRd);
    check(w == 16'hBEEF, "R2 read not write value", w, 16'hBEEF);
    doXfer(1, 1, 16'h0000, 0, 8'h80, "R3 addr read idle");
    readWord(w);
    check(w == 16'h0002, "R3 address port read", w, 16'h0002);

    // R6 R7 R10 R11: stalled transfer
    respHold = 1;
    hostWrite(A_CTRL, 8'h08);
    hostWrite(A_LO, 8'hA5);
    hostWrite(A_HI, 8'hC3);
    c0 = xferCnt;
    hostWrite(A_CMD, 8'h3C);
    check(ctlReq == 1, "R6 request raised", ctlReq, 1);
    check(ctlWrData == 16'hC3A5 && ctlAddrSel == 0 && ctlRead == 0, "R2 outgoing word",
          {ctlRead, ctlAddrSel, ctlWrData}, {2'b00, 16'hC3A5});
    hostRead(A_CTRL, b);
    check(b == expStatus(1, 0), "R7 busy set", b, expStatus(1, 0));
    hostWrite(A_CTRL, 8'h0B);
    hostWrite(A_LO, 8'h11);
    hostWrite(A_HI, 8'h22);
    hostWrite(A_CMD, 8'h77);
    check(ctlWrData == 16'hC3A5 && ctlAddrSel == 0 && ctlRead == 0, "R11 fields held",
          {ctlRead, ctlAddrSel, ctlWrData}, {2'b00, 16'hC3A5});
    respHold = 0; respLat = 0;
    waitIdle("R7 busy cleared");
    repeat (4) @(negedge clk);
    check(xferCnt == c0 + 1, "R10 single completion", xferCnt, c0 + 1);
    check(ctlReq == 0, "R10 no restart", ctlReq, 0);
    shRegs[shRap] = 16'hC3A5;

    // Random mix
    for (int it = 0; it < 40; it++) begin
      bit sel = 1'($urandom_range(0, 3) == 0);
      bit dir = 1'($urandom_range(0, 1));
      logic [15:0] rw = 16'($urandom);
      logic [15:0] got;
      doXfer(sel, dir, rw, $urandom_range(0, 5), 8'($urandom), "R7 random idle");
      readWord(got);
      check(got == shRd, "R9 random read word", got, shRd);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule